// File: doc/BRIEF.md
# Two-Channel DMA Transfer Engine with Termination Control

This block moves 32-bit words from a source address to a destination address on two channels. Every word takes a read cycle followed by a write cycle on one bus master port. Each channel has its own source pointer, destination pointer, remaining-word count and control word. A shared operation register holds a master enable, an NMI flag and an address-error flag. The logic centres on how transfers end. A channel can end on its own, when its count runs out or software drops its enable. Both channels end together when either shared flag becomes set.

Each channel runs in word mode or in 16-byte block mode. In block mode a channel reads four words and then writes them. If fewer than four words remain in the final block, all four reads still take place, but only the remaining number of words is written. A read that faults on alignment is still followed by the write of the word it fetched. The engine halts after that write.

The bus port is valid/ready. The engine raises `bus_valid` with `bus_addr`, `bus_write` and `bus_wdata`, and holds all four steady until it samples `bus_ready` high on a rising edge. On a read, `bus_rdata` is taken in that same handshake cycle. The bus may stall for any number of cycles.

Top module: `dma_term_top`

## Requirements
- R1: A word transfer reads `src` and then writes the word it read to `dst`. `src` advances by 4 when the read handshake completes. `dst` advances by 4 and the count drops by 1 when the write handshake completes.
- R2: When a write brings a channel's count to 0, the engine sets that channel's done bit (control bit 1) and starts no further transfer on that channel.
- R3: `irq[c]` is high exactly while channel c has done = 1 and irq-enable (control bit 2) = 1. Software writing 0 to the done bit clears it. Writing 1 to the done bit leaves it as it was.
- R4: If software clears a channel's enable bit (control bit 0) while the channel is active, the channel issues no further read. It still writes the words it has already read, then stops with done left at 0.
- R5: The NMI flag (operation bit 1) is set one cycle after `nmi_in` is high. The address-error flag (operation bit 2) is set by any handshake whose address is not a multiple of 4. While either flag is set, no channel starts, and the active channel issues no new read. The active channel writes the words it already holds, then halts.
- R6: After a read that sets the address-error flag, the write of that word is still performed. `src`, `dst` and count are left updated by that transfer.
- R7: A channel starts only when its enable is 1, its done bit is 0, its count is nonzero, the master enable (operation bit 0) is 1 and both flags are 0. Flags are cleared only when software writes 0 to them. After that, a channel whose enable is 0 stays idle.
- R8: In block mode (control bit 3 = 1), a channel issues 4 consecutive reads and then min(4, count) writes. The source therefore advances by 16 even when the final block is short.
- R9: Channel 0 has priority over channel 1 when both are eligible. The grant changes only when the engine is idle, which is between whole word transfers or whole blocks.
- R10: While `bus_valid` is high and `bus_ready` is low, `bus_addr`, `bus_write` and `bus_wdata` hold their values on the next cycle.
- R11: The register address is 4 bits wide. Bit 3 = 1 selects the operation register; otherwise bit 2 is the channel and bits 1:0 select src (0), dst (1), count (2, 16 bits) or control (3). All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from cfg_addr) |
| nmi_in | input | 1 | Non-maskable interrupt event; sets the NMI flag |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Bus accepts the request this cycle |
| bus_rdata | input | 32 | Read data, valid in the read handshake cycle |
| irq | output | 2 | Per-channel transfer-end interrupt levels |

## Verification
A wrong phase or word counter inside the engine appears on the bus within one cycle of the next handshake. Typical symptoms are an extra read, a missing write, a write carrying the wrong buffered word, or a read issued after a stop condition. A pointer or count that is updated wrongly shows up as a wrong `bus_addr` on the following access to that channel, and as a wrong value when the register is read back. A done bit that is set wrongly, or left clear wrongly, shows on `irq` in the cycle after the final write when interrupts are enabled, and otherwise through a read of the control word. A flag that fails to stop the engine shows as a read request appearing one cycle after the flag is set.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;

  localparam logic [1:0] IDX_SRC = 2'd0;
  localparam logic [1:0] IDX_DST = 2'd1;
  localparam logic [1:0] IDX_CNT = 2'd2;
  localparam logic [1:0] IDX_CTL = 2'd3;

  localparam int CTL_EN   = 0;
  localparam int CTL_DONE = 1;
  localparam int CTL_IE   = 2;
  localparam int CTL_BLK  = 3;

  localparam int OP_MEN = 0;
  localparam int OP_NMI = 1;
  localparam int OP_AE  = 2;
endpackage

// File: rtl/dma_term_chregs.sv
module dma_term_chregs
  import dma_term_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CW   = 16,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [1:0]    sw_idx,
  input  logic [DW-1:0] sw_wdata,
  input  logic          src_step,
  input  logic          dst_step,
  input  logic          done_set,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic          en,
  output logic          done,
  output logic          ie,
  output logic          blk
);
  logic wr_src, wr_dst, wr_cnt, wr_ctl;

  assign wr_src = sw_we && (sw_idx == IDX_SRC);
  assign wr_dst = sw_we && (sw_idx == IDX_DST);
  assign wr_cnt = sw_we && (sw_idx == IDX_CNT);
  assign wr_ctl = sw_we && (sw_idx == IDX_CTL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src  <= '0;
      dst  <= '0;
      cnt  <= '0;
      en   <= 1'b0;
      done <= 1'b0;
      ie   <= 1'b0;
      blk  <= 1'b0;
    end else begin
      if (wr_src)        src <= sw_wdata[AW-1:0];
      else if (src_step) src <= src + AW'(STEP);

      if (wr_dst)        dst <= sw_wdata[AW-1:0];
      else if (dst_step) dst <= dst + AW'(STEP);

      if (wr_cnt)        cnt <= sw_wdata[CW-1:0];
      else if (dst_step) cnt <= cnt - CW'(1);

      if (wr_ctl) begin
        en  <= sw_wdata[CTL_EN];
        ie  <= sw_wdata[CTL_IE];
        blk <= sw_wdata[CTL_BLK];
      end
      done <= done_set | (done & ~(wr_ctl & ~sw_wdata[CTL_DONE]));
    end
  end
endmodule

// File: rtl/dma_term_glob.sv
module dma_term_glob
  import dma_term_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [DW-1:0] sw_wdata,
  input  logic          nmi_in,
  input  logic          ae_set,
  output logic          men,
  output logic          nmi_flag,
  output logic          ae_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      men      <= 1'b0;
      nmi_flag <= 1'b0;
      ae_flag  <= 1'b0;
    end else begin
      if (sw_we) men <= sw_wdata[OP_MEN];
      nmi_flag <= nmi_in | (nmi_flag & ~(sw_we & ~sw_wdata[OP_NMI]));
      ae_flag  <= ae_set | (ae_flag & ~(sw_we & ~sw_wdata[OP_AE]));
    end
  end
endmodule

// File: rtl/dma_term_arb.sv
module dma_term_arb #(
  parameter int NCH = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [CHW-1:0] pick
);
  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) pick = CHW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/dma_term_engine.sv
module dma_term_engine
  import dma_term_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int CW        = 16,
  parameter int BLK_WORDS = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RW  = $clog2(BLK_WORDS + 1),
  localparam int IW  = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1,
  localparam int LSB = $clog2(DW / 8)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CHW-1:0] start_ch,
  input  logic           start_blk,
  input  logic           halt,
  input  logic           act_en,
  input  logic [AW-1:0]  act_src,
  input  logic [AW-1:0]  act_dst,
  input  logic [CW-1:0]  act_cnt,
  output logic           busy,
  output logic [CHW-1:0] act_ch,
  output logic           bus_valid,
  output logic           bus_write,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  input  logic           bus_ready,
  input  logic [DW-1:0]  bus_rdata,
  output logic           src_step,
  output logic           dst_step,
  output logic           done_set,
  output logic           misal_hit
);
  phase_e        phase;
  logic [RW-1:0] rd_n, wr_n, rd_goal;
  logic [DW-1:0] word_buf [BLK_WORDS];
  logic          hs, misal, last_word;

  assign busy      = (phase != PH_IDLE);
  assign bus_valid = busy;
  assign bus_write = (phase == PH_WRITE);
  assign bus_addr  = bus_write ? act_dst : act_src;
  assign bus_wdata = word_buf[wr_n[IW-1:0]];
  assign hs        = bus_valid && bus_ready;
  assign misal     = |bus_addr[LSB-1:0];
  assign last_word = (act_cnt == CW'(1));

  assign src_step  = hs && (phase == PH_READ);
  assign dst_step  = hs && (phase == PH_WRITE);
  assign done_set  = dst_step && last_word;
  assign misal_hit = hs && misal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      act_ch  <= '0;
      rd_n    <= '0;
      wr_n    <= '0;
      rd_goal <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase   <= PH_READ;
          act_ch  <= start_ch;
          rd_n    <= '0;
          wr_n    <= '0;
          rd_goal <= start_blk ? RW'(BLK_WORDS) : RW'(1);
        end
        PH_READ: if (hs) begin
          rd_n <= rd_n + RW'(1);
          if ((rd_n + RW'(1) == rd_goal) || halt || !act_en || misal) begin
            phase <= PH_WRITE;
            wr_n  <= '0;
          end
        end
        PH_WRITE: if (hs) begin
          wr_n <= wr_n + RW'(1);
          if (last_word || (wr_n + RW'(1) == rd_n)) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (src_step) word_buf[rd_n[IW-1:0]] <= bus_rdata;
  end
endmodule

// File: rtl/dma_term_top.sv
module dma_term_top
  import dma_term_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int CW        = 16,
  parameter int BLK_WORDS = 4,
  localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int REG_AW = CHW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              nmi_in,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_wdata,
  input  logic              bus_ready,
  input  logic [DW-1:0]     bus_rdata,
  output logic [NCH-1:0]    irq
);
  localparam int STEP = DW / 8;

  logic [NCH-1:0][AW-1:0] src_q, dst_q;
  logic [NCH-1:0][CW-1:0] cnt_q;
  logic [NCH-1:0]         en_q, done_q, ie_q, blk_q, elig;
  logic                   men_q, nmi_q, ae_q, glob_flag, halt;
  logic                   busy, start, src_step, dst_step, done_set, misal_hit;
  logic [CHW-1:0]         act_ch, pick;
  logic                   op_sel;
  logic [CHW-1:0]         reg_ch;
  logic [1:0]             reg_idx;

  assign op_sel    = cfg_addr[REG_AW-1];
  assign reg_ch    = cfg_addr[REG_AW-2:2];
  assign reg_idx   = cfg_addr[1:0];
  assign glob_flag = nmi_q | ae_q;
  assign halt      = glob_flag | ~men_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic mine;
    assign mine = (act_ch == CHW'(c));

    dma_term_chregs #(.AW(AW), .DW(DW), .CW(CW), .STEP(STEP)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_we    (cfg_we && !op_sel && (reg_ch == CHW'(c))),
      .sw_idx   (reg_idx),
      .sw_wdata (cfg_wdata),
      .src_step (src_step && mine),
      .dst_step (dst_step && mine),
      .done_set (done_set && mine),
      .src      (src_q[c]),
      .dst      (dst_q[c]),
      .cnt      (cnt_q[c]),
      .en       (en_q[c]),
      .done     (done_q[c]),
      .ie       (ie_q[c]),
      .blk      (blk_q[c])
    );

    assign elig[c] = en_q[c] && !done_q[c] && (cnt_q[c] != '0) && !halt && !busy;
    assign irq[c]  = done_q[c] & ie_q[c];
  end

  dma_term_glob #(.DW(DW)) u_glob (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (cfg_we && op_sel),
    .sw_wdata (cfg_wdata),
    .nmi_in   (nmi_in),
    .ae_set   (misal_hit),
    .men      (men_q),
    .nmi_flag (nmi_q),
    .ae_flag  (ae_q)
  );

  dma_term_arb #(.NCH(NCH)) u_arb (
    .req  (elig),
    .any  (start),
    .pick (pick)
  );

  dma_term_engine #(
    .NCH(NCH), .AW(AW), .DW(DW), .CW(CW), .BLK_WORDS(BLK_WORDS)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_ch  (pick),
    .start_blk (blk_q[pick]),
    .halt      (halt),
    .act_en    (en_q[act_ch]),
    .act_src   (src_q[act_ch]),
    .act_dst   (dst_q[act_ch]),
    .act_cnt   (cnt_q[act_ch]),
    .busy      (busy),
    .act_ch    (act_ch),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .src_step  (src_step),
    .dst_step  (dst_step),
    .done_set  (done_set),
    .misal_hit (misal_hit)
  );

  always_comb begin
    cfg_rdata = '0;
    if (op_sel) begin
      cfg_rdata[OP_MEN] = men_q;
      cfg_rdata[OP_NMI] = nmi_q;
      cfg_rdata[OP_AE]  = ae_q;
    end else begin
      case (reg_idx)
        IDX_SRC: cfg_rdata = DW'(src_q[reg_ch]);
        IDX_DST: cfg_rdata = DW'(dst_q[reg_ch]);
        IDX_CNT: cfg_rdata = DW'(cnt_q[reg_ch]);
        default: begin
          cfg_rdata[CTL_EN]   = en_q[reg_ch];
          cfg_rdata[CTL_DONE] = done_q[reg_ch];
          cfg_rdata[CTL_IE]   = ie_q[reg_ch];
          cfg_rdata[CTL_BLK]  = blk_q[reg_ch];
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_term_chk.sv
module dma_term_chk #(
  parameter int NCH = 2,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_valid,
  input logic                   bus_write,
  input logic                   bus_ready,
  input logic [AW-1:0]          bus_addr,
  input logic [DW-1:0]          bus_wdata,
  input logic                   cfg_we,
  input logic [NCH-1:0]         irq,
  input logic                   glob_flag,
  input logic [NCH-1:0]         done_q,
  input logic [NCH-1:0][CW-1:0] cnt_q
);
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata))
    else $error("bus request changed while stalled"); // R10

  AST_IRQ_FALL_BY_SW: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(irq) & ~irq)) |-> $past(cfg_we))
    else $error("irq dropped without a register write"); // R3

  AST_NO_READ_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(glob_flag) && bus_valid && !bus_write |-> $past(bus_valid && !bus_write && !bus_ready))
    else $error("new read issued while a global flag was set"); // R5

  AST_MISAL_READ_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && !bus_write && (|bus_addr[1:0]) |=> bus_valid && bus_write)
    else $error("faulting read not followed by its write"); // R6

  for (genvar i = 0; i < NCH; i++) begin : g_done
    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q[i]) |-> (cnt_q[i] == '0))
      else $error("done set with nonzero count"); // R2
  end
endmodule

bind dma_term_top dma_term_chk #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .cfg_we    (cfg_we),
  .irq       (irq),
  .glob_flag (glob_flag),
  .done_q    (done_q),
  .cnt_q     (cnt_q)
);

// File: tb/dma_term_top_tb.sv
module dma_term_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_OP = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        nmi_in = 1'b0;
  logic        bus_valid, bus_write;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_ready = 1'b1;
  logic [1:0]  irq;
  bit          stall = 1'b0;
  int          rdy_cnt = 0;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          cmp_on = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  assign bus_rdata = mem_word(bus_addr);

  dma_term_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .nmi_in(nmi_in),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_src [2];
  logic [31:0] m_dst [2];
  logic [15:0] m_cnt [2];
  bit          m_en [2], m_done [2], m_ie [2], m_blk [2];
  bit          m_men, m_nmi, m_ae;
  int          m_ph, m_act, m_rdn, m_nrd, m_wri;
  logic [31:0] m_buf [4];

  function automatic logic [31:0] m_read(logic [3:0] a);
    int c;
    if (a[3]) return {29'd0, m_ae, m_nmi, m_men};
    c = int'(a[2]);
    case (a[1:0])
      2'd0: return m_src[c];
      2'd1: return m_dst[c];
      2'd2: return {16'd0, m_cnt[c]};
      default: return {28'd0, m_blk[c], m_ie[c], m_done[c], m_en[c]};
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] a;
    bit hs, mis, halt, o_nmi, o_ae;
    bit el [2];
    bit dset [2];
    bit o_done [2];
    int c;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_src[i] = '0; m_dst[i] = '0; m_cnt[i] = '0;
        m_en[i] = 0; m_done[i] = 0; m_ie[i] = 0; m_blk[i] = 0;
      end
      m_men = 0; m_nmi = 0; m_ae = 0;
      m_ph = 0; m_act = 0; m_rdn = 0; m_nrd = 0; m_wri = 0;
    end else begin
      hs   = (m_ph != 0) && bus_ready;
      a    = (m_ph == 2) ? m_dst[m_act] : m_src[m_act];
      mis  = hs && (a[1:0] != 2'b00);
      halt = !m_men || m_nmi || m_ae;
      for (int i = 0; i < 2; i++) begin
        dset[i]   = 0;
        o_done[i] = m_done[i];
        el[i]     = m_en[i] && !m_done[i] && (m_cnt[i] != 0) && !halt && (m_ph == 0);
      end
      o_nmi = m_nmi; o_ae = m_ae;
      if (m_ph == 1 && hs) begin
        m_buf[m_rdn] = mem_word(a);
        m_src[m_act] = m_src[m_act] + 4;
        if ((m_rdn + 1 == m_nrd) || halt || !m_en[m_act] || mis) begin
          m_ph = 2; m_wri = 0;
        end
        m_rdn++;
      end else if (m_ph == 2 && hs) begin
        m_dst[m_act] = m_dst[m_act] + 4;
        if (m_cnt[m_act] == 1) begin
          dset[m_act] = 1; m_ph = 0;
        end else if (m_wri + 1 == m_rdn) m_ph = 0;
        m_cnt[m_act] = m_cnt[m_act] - 1;
        m_wri++;
      end else if (m_ph == 0 && (el[0] || el[1])) begin
        m_act = el[0] ? 0 : 1;
        m_ph = 1; m_rdn = 0;
        m_nrd = m_blk[m_act] ? 4 : 1;
      end
      for (int i = 0; i < 2; i++) m_done[i] = m_done[i] | dset[i];
      m_ae  = m_ae | mis;
      m_nmi = m_nmi | nmi_in;
      if (cfg_we) begin
        if (cfg_addr[3]) begin
          m_men = cfg_wdata[0];
          m_nmi = nmi_in | (o_nmi & cfg_wdata[1]);
          m_ae  = mis | (o_ae & cfg_wdata[2]);
        end else begin
          c = int'(cfg_addr[2]);
          case (cfg_addr[1:0])
            2'd0: m_src[c] = cfg_wdata;
            2'd1: m_dst[c] = cfg_wdata;
            2'd2: m_cnt[c] = cfg_wdata[15:0];
            default: begin
              m_en[c]   = cfg_wdata[0];
              m_ie[c]   = cfg_wdata[2];
              m_blk[c]  = cfg_wdata[3];
              m_done[c] = dset[c] | (o_done[c] & cfg_wdata[1]);
            end
          endcase
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R10 valid", {31'd0, bus_valid}, {31'd0, m_ph != 0});
      if (m_ph != 0 && bus_valid) begin
        check("R1 direction", {31'd0, bus_write}, {31'd0, m_ph == 2});
        check("R1 address", bus_addr, (m_ph == 2) ? m_dst[m_act] : m_src[m_act]);
        if (m_ph == 2) check("R1 write data", bus_wdata, m_buf[m_wri]);
      end
      check("R3 irq", {30'd0, irq}, {30'd0, m_done[1] & m_ie[1], m_done[0] & m_ie[0]});
    end
  end

  always @(negedge clk) begin
    rdy_cnt++;
    bus_ready <= !stall || (rdy_cnt % 3 != 0);
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(string req, logic [3:0] a, logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, m_read(a));
    check(req, cfg_rdata, exp);
  endtask

  task automatic setup(int c, logic [31:0] s, logic [31:0] d, logic [15:0] n);
    wr({1'b0, c[0], 2'd0}, s);
    wr({1'b0, c[0], 2'd1}, d);
    wr({1'b0, c[0], 2'd2}, {16'd0, n});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R11: reset values and register map
    for (int i = 0; i < 9; i++) rd("R11 reset", 4'(i), 32'd0);

    // R1 R2 R3: three word transfers on channel 0 with irq enabled
    wr(A_OP, 32'h1);
    setup(0, 32'h100, 32'h200, 16'd3);
    wr(4'd3, 32'h5);
    repeat (20) @(negedge clk);
    rd("R2 count zero", 4'd2, 32'd0);
    rd("R2 done set", 4'd3, 32'h7);
    rd("R1 src advanced", 4'd0, 32'h10C);
    rd("R1 dst advanced", 4'd1, 32'h20C);
    check("R3 irq high", {31'd0, irq[0]}, 32'd1);

    // R3: writing 1 to done keeps it, writing 0 clears it
    wr(4'd3, 32'h7);
    check("R3 done write 1 no effect", {31'd0, irq[0]}, 32'd1);
    wr(4'd3, 32'h5);
    check("R3 irq cleared", {31'd0, irq[0]}, 32'd0);
    wr(4'd3, 32'h0);

    // R9: both eligible together, channel 0 first; bus stalls on
    stall = 1'b1;
    wr(A_OP, 32'h0);
    setup(0, 32'h300, 32'h400, 16'd2);
    setup(1, 32'h1000, 32'h2000, 16'd2);
    wr(4'd3, 32'h1);
    wr(4'd7, 32'h1);
    wr(A_OP, 32'h1);
    while (!bus_valid) @(negedge clk);
    check("R9 channel 0 first", bus_addr, 32'h300);
    repeat (40) @(negedge clk);
    rd("R9 ch1 finished", 4'd6, 32'd0);

    // R4: disable channel 1 mid-run
    setup(1, 32'h3000, 32'h4000, 16'd100);
    wr(4'd7, 32'h1);
    repeat (9) @(negedge clk);
    wr(4'd7, 32'h0);
    repeat (12) @(negedge clk);
    check("R4 bus idle", {31'd0, bus_valid}, 32'd0);
    rd("R4 done stays 0", 4'd7, 32'h0);
    rd("R4 count frozen", 4'd6, {16'd0, m_cnt[1]});

    // R5 R7: NMI stops both, resume only enabled channel
    setup(0, 32'h500, 32'h600, 16'd30);
    setup(1, 32'h5000, 32'h6000, 16'd30);
    wr(4'd3, 32'h1);
    wr(4'd7, 32'h1);
    repeat (7) @(negedge clk);
    nmi_in = 1'b1;
    @(negedge clk);
    nmi_in = 1'b0;
    repeat (10) @(negedge clk);
    check("R5 halted", {31'd0, bus_valid}, 32'd0);
    rd("R5 nmi flag", A_OP, 32'h3);
    wr(4'd3, 32'h0);
    wr(A_OP, 32'h1);
    repeat (250) @(negedge clk);
    rd("R7 enabled ch1 resumed", 4'd6, 32'd0);
    rd("R7 disabled ch0 idle", 4'd2, {16'd0, m_cnt[0]});
    wr(4'd3, 32'h1);
    repeat (250) @(negedge clk);
    rd("R7 ch0 resumed", 4'd2, 32'd0);

    // R8: block mode, 6 words -> 4r4w then 4r2w
    stall = 1'b0;
    setup(0, 32'h800, 32'h900, 16'd6);
    wr(4'd3, 32'h9);
    repeat (40) @(negedge clk);
    rd("R8 count", 4'd2, 32'd0);
    rd("R8 src +32", 4'd0, 32'h820);
    rd("R8 dst +24", 4'd1, 32'h918);
    rd("R8 done", 4'd3, 32'hB);

    // R6 R5 R7: misaligned read on channel 1
    setup(1, 32'hA02, 32'hB00, 16'd5);
    wr(4'd7, 32'h1);
    repeat (10) @(negedge clk);
    rd("R6 count updated", 4'd6, 32'd4);
    rd("R6 dst updated", 4'd5, 32'hB04);
    rd("R6 src updated", 4'd4, 32'hA06);
    rd("R5 ae flag", A_OP, 32'h5);
    setup(0, 32'hC00, 32'hD00, 16'd2);
    wr(4'd3, 32'h1);
    repeat (10) @(negedge clk);
    rd("R5 ch0 blocked by flag", 4'd2, 32'd2);
    wr(4'd7, 32'h0);
    wr(A_OP, 32'h1);
    repeat (20) @(negedge clk);
    rd("R7 ch0 ran after clear", 4'd2, 32'd0);
    rd("R7 ch1 stays idle", 4'd6, 32'd4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule